// File: doc/BRIEF.md
# Flash Status Busy-Poll Engine

This block runs the wait that follows an operation issued to a serial NAND flash device. When pulsed with an operation kind (page read, page program, block erase or device reset), it stays quiet for an initial settling delay. It then asks the serial shifter to run a get-feature read of the status register. While the returned byte reports the device as busy, it waits a poll interval and asks again. The initial delay and the poll interval are both chosen by the operation kind.

The wait ends when a status byte comes back with the busy bit clear. It also ends when a busy status read completes after the timeout budget, counted from the start pulse, has been used up. The last status byte is latched, and done pulses for one cycle. The byte is decoded into program-fail, erase-fail and a two-bit ECC verdict. A timeout flag overrides the decode. Delays come from a microsecond tick that is prescaled from the clock using a cycles-per-microsecond parameter. Every delay parameter must be at least one microsecond.

Top module: `nand_busy_poller`

## Requirements
- R1: After reset, busy_o, xfer_req_o and done_o are low, and status_o, prog_fail_o, erase_fail_o, ecc_o and timeout_o are zero.
- R2: A start_i pulse while idle latches op_i (0 read, 1 program, 2 erase, 3 reset) and raises busy_o. The first status request rises exactly INIT×CYC_PER_US clock cycles after the start edge, where INIT is 6 µs for read, 75 for program, 250 for erase and 5 for reset.
- R3: Every status request presents opcode 0x0F and address 0xC0. xfer_req_o stays high until the cycle in which xfer_rvalid_i is sampled high, then drops.
- R4: A returned byte with bit 0 set (busy), received before the timeout, makes the next request rise exactly POLL×CYC_PER_US cycles after the response edge. POLL is 5 µs for read, 15 for program, 50 for erase and 5 for reset.
- R5: A returned byte with bit 0 clear ends the wait. In the next cycle done_o is high for exactly one cycle, status_o holds the byte, and busy_o is low.
- R6: Without timeout, prog_fail_o equals status bit 3 and erase_fail_o equals status bit 2.
- R7: Without timeout, ecc_o equals status bits 5:4: 00 clean, 01 corrected, 10 uncorrectable, and 11 is reported as a reserved/error code.
- R8: A busy response that completes TIMEOUT_US×CYC_PER_US or more cycles after the start edge ends the wait. It sets timeout_o, keeps the byte in status_o, and forces prog_fail_o, erase_fail_o and ecc_o to zero.
- R9: A start_i pulse while busy_o is high is ignored. It changes neither the operation kind nor the timing.
- R10: status_o and all flags change only together with done_o and hold their values until the next wait completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a wait (sampled while idle) |
| op_i | input | 2 | Operation kind: 0 read, 1 program, 2 erase, 3 reset |
| busy_o | output | 1 | A wait is in progress |
| xfer_req_o | output | 1 | Request a status-register read from the shifter |
| xfer_opcode_o | output | 8 | Opcode of the requested transfer (0x0F) |
| xfer_addr_o | output | 8 | Feature address of the requested transfer (0xC0) |
| xfer_rvalid_i | input | 1 | Shifter returns the status byte |
| xfer_rdata_i | input | 8 | Returned status byte |
| done_o | output | 1 | One-cycle completion pulse |
| status_o | output | 8 | Last status byte |
| prog_fail_o | output | 1 | Program failed (no timeout) |
| erase_fail_o | output | 1 | Erase failed (no timeout) |
| ecc_o | output | 2 | ECC verdict (no timeout) |
| timeout_o | output | 1 | Busy never cleared within the budget |

## Verification
The bench holds a cycle-level model of the wait. It compares request timing for all four operation kinds, including several busy rounds. A design that picked the wrong delay pair, or that kept prescaler phase across a reload, would raise its request a few cycles early or late. The erase case is run against a short timeout budget until it expires. This catches a design that keeps polling, or that leaks stale fail or ECC bits under a timeout. A second start pulse sent in the middle of a wait must leave the schedule untouched. All four ECC codes, including the reserved one, are returned and decoded.

// File: rtl/nbp_pkg.sv
package nbp_pkg;
  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_PROG  = 2'd1,
    OP_ERASE = 2'd2,
    OP_RESET = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_ISSUE = 2'd2
  } st_e;

  localparam logic [7:0] GET_FEATURE_OPC = 8'h0F;
  localparam logic [7:0] STATUS_REG_ADDR = 8'hC0;

  localparam int BUSY_POS  = 0;
  localparam int EFAIL_POS = 2;
  localparam int PFAIL_POS = 3;
  localparam int ECC_LO    = 4;
endpackage

// File: rtl/nbp_us_tick.sv
module nbp_us_tick #(
  parameter int CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int W = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [W-1:0] LAST = W'(CYC_PER_US - 1);

  logic [W-1:0] cnt_q, cnt_d;

  assign tick_o = run_i && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (tick_o) cnt_d = '0;
    else if (run_i)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nbp_delay_sel.sv
module nbp_delay_sel
  import nbp_pkg::*;
#(
  parameter int DW            = 9,
  parameter int RD_INIT_US    = 6,
  parameter int RD_POLL_US    = 5,
  parameter int PG_INIT_US    = 75,
  parameter int PG_POLL_US    = 15,
  parameter int ER_INIT_US    = 250,
  parameter int ER_POLL_US    = 50,
  parameter int RST_INIT_US   = 5,
  parameter int RST_POLL_US   = 5
) (
  input  op_e           op_i,
  output logic [DW-1:0] init_o,
  output logic [DW-1:0] poll_o
);
  always_comb begin
    unique case (op_i)
      OP_READ:  begin init_o = DW'(RD_INIT_US);  poll_o = DW'(RD_POLL_US);  end
      OP_PROG:  begin init_o = DW'(PG_INIT_US);  poll_o = DW'(PG_POLL_US);  end
      OP_ERASE: begin init_o = DW'(ER_INIT_US);  poll_o = DW'(ER_POLL_US);  end
      default:  begin init_o = DW'(RST_INIT_US); poll_o = DW'(RST_POLL_US); end
    endcase
  end
endmodule

// File: rtl/nbp_delay_cnt.sv
module nbp_delay_cnt #(
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          tick_i,
  output logic          expire_o
);
  logic [DW-1:0] cnt_q, cnt_d;

  assign expire_o = tick_i && (cnt_q == DW'(1));

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                    cnt_d = load_val_i;
    else if (tick_i && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/nbp_status_decode.sv
module nbp_status_decode
  import nbp_pkg::*;
(
  input  logic [7:0] status_i,
  input  logic       timeout_i,
  output logic       prog_fail_o,
  output logic       erase_fail_o,
  output logic [1:0] ecc_o
);
  assign prog_fail_o  = status_i[PFAIL_POS] & ~timeout_i;
  assign erase_fail_o = status_i[EFAIL_POS] & ~timeout_i;
  assign ecc_o        = timeout_i ? 2'b00 : status_i[ECC_LO +: 2];
endmodule

// File: rtl/nand_busy_poller.sv
module nand_busy_poller
  import nbp_pkg::*;
#(
  parameter int CYC_PER_US  = 100,
  parameter int TIMEOUT_US  = 400000,
  parameter int RD_INIT_US  = 6,
  parameter int RD_POLL_US  = 5,
  parameter int PG_INIT_US  = 75,
  parameter int PG_POLL_US  = 15,
  parameter int ER_INIT_US  = 250,
  parameter int ER_POLL_US  = 50,
  parameter int RST_INIT_US = 5,
  parameter int RST_POLL_US = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [1:0] op_i,
  output logic       busy_o,
  output logic       xfer_req_o,
  output logic [7:0] xfer_opcode_o,
  output logic [7:0] xfer_addr_o,
  input  logic       xfer_rvalid_i,
  input  logic [7:0] xfer_rdata_i,
  output logic       done_o,
  output logic [7:0] status_o,
  output logic       prog_fail_o,
  output logic       erase_fail_o,
  output logic [1:0] ecc_o,
  output logic       timeout_o
);
  localparam int MAX_A   = (RD_INIT_US > PG_INIT_US) ? RD_INIT_US : PG_INIT_US;
  localparam int MAX_B   = (ER_INIT_US > RST_INIT_US) ? ER_INIT_US : RST_INIT_US;
  localparam int MAX_C   = (RD_POLL_US > PG_POLL_US) ? RD_POLL_US : PG_POLL_US;
  localparam int MAX_D   = (ER_POLL_US > RST_POLL_US) ? ER_POLL_US : RST_POLL_US;
  localparam int MAX_AB  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_CD  = (MAX_C > MAX_D) ? MAX_C : MAX_D;
  localparam int MAX_DLY = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
  localparam int DW      = $clog2(MAX_DLY + 1);
  localparam int TO_CYC  = TIMEOUT_US * CYC_PER_US;
  localparam int TW      = $clog2(TO_CYC + 1);
  localparam logic [TW-1:0] TO_LAST = TW'(TO_CYC - 1);

  st_e           st_q, st_d;
  op_e           op_q;
  op_e           sel_op;
  logic          accept;
  logic          load_dly;
  logic [DW-1:0] dly_val, init_us, poll_us;
  logic          tick, expire;
  logic [TW-1:0] cyc_q;
  logic          late;
  logic          fin;
  logic          rsp_busy;
  logic [7:0]    status_q;
  logic          to_q, done_q;

  assign accept   = (st_q == ST_IDLE) && start_i;
  assign sel_op   = (st_q == ST_IDLE) ? op_e'(op_i) : op_q;
  assign rsp_busy = xfer_rdata_i[BUSY_POS];
  assign late     = (cyc_q >= TO_LAST);

  nbp_delay_sel #(
    .DW(DW),
    .RD_INIT_US(RD_INIT_US),   .RD_POLL_US(RD_POLL_US),
    .PG_INIT_US(PG_INIT_US),   .PG_POLL_US(PG_POLL_US),
    .ER_INIT_US(ER_INIT_US),   .ER_POLL_US(ER_POLL_US),
    .RST_INIT_US(RST_INIT_US), .RST_POLL_US(RST_POLL_US)
  ) u_sel (
    .op_i  (sel_op),
    .init_o(init_us),
    .poll_o(poll_us)
  );

  nbp_us_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (load_dly),
    .run_i (st_q == ST_WAIT),
    .tick_o(tick)
  );

  nbp_delay_cnt #(.DW(DW)) u_dly (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load_dly),
    .load_val_i(dly_val),
    .tick_i    (tick),
    .expire_o  (expire)
  );

  always_comb begin
    st_d     = st_q;
    load_dly = 1'b0;
    dly_val  = init_us;
    fin      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d     = ST_WAIT;
          load_dly = 1'b1;
          dly_val  = init_us;
        end
      end
      ST_WAIT: begin
        if (expire) st_d = ST_ISSUE;
      end
      ST_ISSUE: begin
        if (xfer_rvalid_i) begin
          if (rsp_busy && !late) begin
            st_d     = ST_WAIT;
            load_dly = 1'b1;
            dly_val  = poll_us;
          end else begin
            st_d = ST_IDLE;
            fin  = 1'b1;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      op_q <= OP_READ;
    end else begin
      st_q <= st_d;
      if (accept) op_q <= op_e'(op_i);
    end
  end

  // elapsed-cycle budget, restarted by an accepted start, saturating
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          cyc_q <= '0;
    else if (accept)                     cyc_q <= '0;
    else if (st_q != ST_IDLE && !late)   cyc_q <= cyc_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      to_q     <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin;
      if (fin) begin
        status_q <= xfer_rdata_i;
        to_q     <= rsp_busy;
      end
    end
  end

  nbp_status_decode u_dec (
    .status_i    (status_q),
    .timeout_i   (to_q),
    .prog_fail_o (prog_fail_o),
    .erase_fail_o(erase_fail_o),
    .ecc_o       (ecc_o)
  );

  assign busy_o        = (st_q != ST_IDLE);
  assign xfer_req_o    = (st_q == ST_ISSUE);
  assign xfer_opcode_o = GET_FEATURE_OPC;
  assign xfer_addr_o   = STATUS_REG_ADDR;
  assign done_o        = done_q;
  assign status_o      = status_q;
  assign timeout_o     = to_q;
endmodule

// File: rtl/nand_busy_poller_chk.sv
module nand_busy_poller_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic       busy_o,
  input logic       xfer_req_o,
  input logic [7:0] xfer_opcode_o,
  input logic [7:0] xfer_addr_o,
  input logic       xfer_rvalid_i,
  input logic       done_o,
  input logic [7:0] status_o,
  input logic       prog_fail_o,
  input logic       erase_fail_o,
  input logic [1:0] ecc_o,
  input logic       timeout_o
);
  AST_REQ_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> (xfer_opcode_o == 8'h0F && xfer_addr_o == 8'hC0)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_o && !xfer_rvalid_i) |=> xfer_req_o); // R3
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_req_o && xfer_rvalid_i) |=> !xfer_req_o); // R3
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R5
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R5
  AST_TIMEOUT_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |-> (!prog_fail_o && !erase_fail_o && ecc_o == 2'b00)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !xfer_rvalid_i) |=> busy_o); // R9
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(status_o) || !$stable(timeout_o)) |-> done_o); // R10
endmodule

bind nand_busy_poller nand_busy_poller_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .busy_o       (busy_o),
  .xfer_req_o   (xfer_req_o),
  .xfer_opcode_o(xfer_opcode_o),
  .xfer_addr_o  (xfer_addr_o),
  .xfer_rvalid_i(xfer_rvalid_i),
  .done_o       (done_o),
  .status_o     (status_o),
  .prog_fail_o  (prog_fail_o),
  .erase_fail_o (erase_fail_o),
  .ecc_o        (ecc_o),
  .timeout_o    (timeout_o)
);

// File: tb/nand_busy_poller_tb_top.sv
module nand_busy_poller_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CPU        = 2;
  localparam int TO_US      = 400;
  localparam int TO_CYC     = TO_US * CPU;

  logic       clk;
  logic       rst_n;
  logic       start_i;
  logic [1:0] op_i;
  logic       busy_o, xfer_req_o, xfer_rvalid_i, done_o;
  logic [7:0] xfer_opcode_o, xfer_addr_o, xfer_rdata_i, status_o;
  logic       prog_fail_o, erase_fail_o, timeout_o;
  logic [1:0] ecc_o;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  byte unsigned rq[$];

  // behavioural model state
  int m_state = 0;   // 0 idle, 1 waiting, 2 reading
  int m_wait  = 0;
  int m_t     = 0;
  int m_op    = 0;
  int m_done  = 0;
  int m_stat  = 0;
  int m_to    = 0;

  nand_busy_poller #(.CYC_PER_US(CPU), .TIMEOUT_US(TO_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
    .busy_o(busy_o), .xfer_req_o(xfer_req_o),
    .xfer_opcode_o(xfer_opcode_o), .xfer_addr_o(xfer_addr_o),
    .xfer_rvalid_i(xfer_rvalid_i), .xfer_rdata_i(xfer_rdata_i),
    .done_o(done_o), .status_o(status_o),
    .prog_fail_o(prog_fail_o), .erase_fail_o(erase_fail_o),
    .ecc_o(ecc_o), .timeout_o(timeout_o)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD/2) clk = ~clk;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int init_cyc(input int op);
    case (op)
      0: return 6 * CPU;
      1: return 75 * CPU;
      2: return 250 * CPU;
      default: return 5 * CPU;
    endcase
  endfunction

  function automatic int poll_cyc(input int op);
    case (op)
      0: return 5 * CPU;
      1: return 15 * CPU;
      2: return 50 * CPU;
      default: return 5 * CPU;
    endcase
  endfunction

  // reference model, advanced on every clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state = 0; m_wait = 0; m_t = 0; m_op = 0;
      m_done = 0; m_stat = 0; m_to = 0;
    end else begin
      m_done = 0;
      if (m_state == 0) begin
        if (start_i) begin
          m_state = 1; m_op = op_i; m_wait = init_cyc(op_i); m_t = 0;
        end
      end else if (m_state == 1) begin
        m_t++;
        m_wait--;
        if (m_wait == 0) m_state = 2;
      end else begin
        m_t++;
        if (xfer_rvalid_i) begin
          if (xfer_rdata_i[0] && m_t < TO_CYC) begin
            m_state = 1; m_wait = poll_cyc(m_op);
          end else begin
            m_state = 0; m_done = 1; m_stat = xfer_rdata_i; m_to = xfer_rdata_i[0];
          end
        end
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R2/R4 busy_o", busy_o, m_state != 0);
      chk("R2/R4 xfer_req_o timing", xfer_req_o, m_state == 2);
      chk("R5 done_o", done_o, m_done);
      chk("R10 status_o", status_o, m_stat);
      chk("R8 timeout_o", timeout_o, m_to);
      chk("R6 prog_fail_o", prog_fail_o, m_to ? 0 : (m_stat >> 3) & 1);
      chk("R6 erase_fail_o", erase_fail_o, m_to ? 0 : (m_stat >> 2) & 1);
      chk("R7 ecc_o", ecc_o, m_to ? 0 : (m_stat >> 4) & 3);
      if (xfer_req_o) begin
        chk("R3 opcode", xfer_opcode_o, 8'h0F);
        chk("R3 address", xfer_addr_o, 8'hC0);
      end
    end
  end

  // shifter stand-in: answers two cycles after a request appears
  initial begin
    int lat = 0;
    xfer_rvalid_i = 1'b0;
    xfer_rdata_i  = 8'h00;
    forever begin
      @(negedge clk);
      if (xfer_rvalid_i) begin
        xfer_rvalid_i = 1'b0;
        lat = 0;
      end else if (xfer_req_o) begin
        lat++;
        if (lat >= 2) begin
          xfer_rvalid_i = 1'b1;
          xfer_rdata_i  = (rq.size() > 0) ? rq.pop_front() : 8'h00;
        end
      end else begin
        lat = 0;
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic go(input int op);
    @(negedge clk);
    start_i = 1'b1;
    op_i    = 2'(op);
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int seen = 0;
    for (int i = 0; i < 5000 && !seen; i++) begin
      @(negedge clk);
      if (done_o) seen = 1;
    end
    chk({tag, " done reached"}, seen, 1);
  endtask

  initial begin
    rst_n   = 1'b0;
    start_i = 1'b0;
    op_i    = 2'd0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 busy_o", busy_o, 0);
    chk("R1 xfer_req_o", xfer_req_o, 0);
    chk("R1 done_o", done_o, 0);
    chk("R1 status_o", status_o, 0);
    chk("R1 flags", {timeout_o, prog_fail_o, erase_fail_o, ecc_o}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R4 R7: read, two busy rounds, corrected ECC
    rq = '{8'h01, 8'h01, 8'h10};
    go(0);
    wait_done("R5 read");
    chk("R7 corrected", ecc_o, 2'b01);

    // R6: program fail
    rq = '{8'h09, 8'h08};
    go(1);
    wait_done("R5 program");
    chk("R6 prog_fail", prog_fail_o, 1);

    // R9: stray start during erase wait, then erase fail
    rq = '{8'h01, 8'h04};
    go(2);
    repeat (20) @(negedge clk);
    go(0);
    wait_done("R9 erase");
    chk("R9 erase kept", erase_fail_o, 1);

    // R2: reset op, clean
    rq = '{8'h00};
    go(3);
    wait_done("R5 reset");
    chk("R7 clean", ecc_o, 2'b00);

    // R7: uncorrectable and reserved codes
    rq = '{8'h20};
    go(0);
    wait_done("R7 uncorr");
    chk("R7 uncorrectable", ecc_o, 2'b10);
    rq = '{8'h30};
    go(0);
    wait_done("R7 rsvd");
    chk("R7 reserved", ecc_o, 2'b11);

    // R10: results held while idle
    repeat (30) @(negedge clk);
    chk("R10 held", status_o, 8'h30);

    // R8: erase never clears
    rq = '{8'h3D, 8'h3D, 8'h3D, 8'h3D, 8'h3D, 8'h3D, 8'h3D};
    go(2);
    wait_done("R8 timeout");
    chk("R8 timeout_o", timeout_o, 1);
    chk("R8 status kept", status_o, 8'h3D);
    chk("R8 masked", {prog_fail_o, erase_fail_o, ecc_o}, 0);
    rq.delete();
    repeat (10) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule